// File: doc/BRIEF.md
# Network-Time Ident Pulse Regenerator

This block sits in a timing receiver whose 125 MHz clock is locked to the network carrier, so every clock cycle stands for 8 ns of network time. On each cycle it receives the current network time as a nanosecond count. From that count it rebuilds a 100 kHz ident pulse train, one pulse every 10000 ns (1250 cycles). The pulse has the frequency and phase that a local reference synthesizer would produce. The phase of the train, relative to the time ticks, is set by an offset word that arrives over the network with a load strobe.

The block does not divide down a free-running counter. It tracks `time mod 10000` with an 8 ns step and recomputes it from the full time value whenever the time input does not advance by exactly one step. A small scheduler lets downstream logic ask for a one-cycle trigger on the Nth ident pulse, so that actions such as starting a simple waveform line up with the regenerated edges.

All outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

Top module: `ident_resynth`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are low after that edge.
- R2: `ident_o` is high for exactly the cycle after an edge whose sampled time T satisfies ((T − A) mod 10000) < 8, where A is the active offset in ns. With time advancing 8 ns per cycle, this gives exactly one pulse every 1250 cycles.
- R3: A loaded offset waits in a pending register. It becomes active only after the next ident pulse, and that pulse is still placed using the previous offset. A later load before that pulse replaces the pending value.
- R4: The offset input is 14 bits wide. A loaded value of 10000 or more is reduced by 10000 before use, so the active offset is always in the range 0 to 9999.
- R5: After `arm_i` is sampled high with `arm_cnt_i` = N ≥ 1, `trig_o` is high together with the Nth ident pulse whose deciding edge comes after the arming edge. The trigger fires once, and the scheduler is then idle.
- R6: Arming with N = 0 cancels any pending schedule. A new arm replaces the previous schedule, and the ident pulse decided on the arming edge itself is not counted.
- R7: If the sampled time differs from the previous sample plus 8, `resync_o` is high for the following cycle. The phase is then taken from the new time value directly, so R2 holds across the jump with no lost cycle.
- R8: The first sample after reset is treated as a time jump, so `resync_o` is high one cycle after the first edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock locked to network carrier |
| rst | input | 1 | Synchronous active-high reset |
| net_time_i | input | 64 | Network time in ns, valid each cycle |
| ofs_load_i | input | 1 | Strobe: capture `ofs_val_i` as pending offset |
| ofs_val_i | input | 14 | Ident-to-tick offset in ns |
| arm_i | input | 1 | Strobe: arm the trigger scheduler |
| arm_cnt_i | input | 16 | Number N of ident pulses until the trigger |
| ident_o | output | 1 | Regenerated ident pulse, one cycle wide |
| trig_o | output | 1 | Scheduled trigger, coincident with an ident pulse |
| resync_o | output | 1 | One-cycle flag after a time discontinuity |

## Verification
The time input is swept through several full periods, cycle by cycle, with offsets of zero, a mid-range value, the top value 9999 and an over-range value. This exposes off-by-one placement, wrap errors and a missing modulo reduction. An offset is loaded in the middle of a period, which tells a design that applies it at once apart from one that waits for the next boundary. Forward and backward jumps in time separate a tracker that truly recomputes its phase from one that keeps counting. The trigger is armed with counts of 3, 1 and then cancelled with 0, which tells correct edge counting apart from early or stale triggers.

// File: rtl/ident_resynth_pkg.sv
package ident_resynth_pkg;

  // (a - b) mod p for a, b already in [0, p)
  function automatic int unsigned circ_sub(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned p);
    return (a >= b) ? (a - b) : (a + p - b);
  endfunction

  // single fold into [0, p) for v < 2p
  function automatic int unsigned fold_once(input int unsigned v,
                                            input int unsigned p);
    return (v >= p) ? (v - p) : v;
  endfunction

endpackage

// File: rtl/ident_phase_track.sv
module ident_phase_track
  import ident_resynth_pkg::*;
#(
  parameter int TIME_W    = 64,
  parameter int PERIOD_NS = 10000,
  parameter int STEP_NS   = 8,
  parameter int PH_W      = $clog2(PERIOD_NS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_i,
  input  logic [PH_W-1:0]   ofs_i,
  output logic              fire_o,
  output logic              jump_o
);

  logic [TIME_W-1:0] t_prev;
  logic [PH_W-1:0]   ph_q;
  logic [PH_W-1:0]   ph_now;
  logic              vld_q;

  always_comb begin
    jump_o = !vld_q || (time_i != t_prev + TIME_W'(STEP_NS));
    if (jump_o)
      ph_now = PH_W'(time_i % TIME_W'(PERIOD_NS));
    else
      ph_now = PH_W'(fold_once(32'(ph_q) + STEP_NS, PERIOD_NS));
    fire_o = circ_sub(32'(ph_now), 32'(ofs_i), PERIOD_NS) < STEP_NS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      t_prev <= '0;
      ph_q   <= '0;
    end else begin
      vld_q  <= 1'b1;
      t_prev <= time_i;
      ph_q   <= ph_now;
    end
  end

  // R7: the tracked phase never leaves one period
  p_phase_range_r7: assert property (@(posedge clk) disable iff (rst)
    32'(ph_q) < PERIOD_NS);

endmodule

// File: rtl/ident_offset_reg.sv
module ident_offset_reg
  import ident_resynth_pkg::*;
#(
  parameter int PERIOD_NS = 10000,
  parameter int PH_W      = $clog2(PERIOD_NS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [PH_W-1:0] val_i,
  input  logic            commit_i,
  output logic [PH_W-1:0] ofs_o
);

  logic [PH_W-1:0] act_q;
  logic [PH_W-1:0] pend_q;
  logic            pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= '0;
      pend_q   <= '0;
      pend_vld <= 1'b0;
    end else begin
      if (commit_i && pend_vld)
        act_q <= pend_q;
      if (load_i) begin
        pend_q   <= PH_W'(fold_once(32'(val_i), PERIOD_NS));
        pend_vld <= 1'b1;
      end else if (commit_i) begin
        pend_vld <= 1'b0;
      end
    end
  end

  assign ofs_o = act_q;

  // R4: held offsets always lie inside one period
  p_offset_range_r4: assert property (@(posedge clk) disable iff (rst)
    (32'(act_q) < PERIOD_NS) && (32'(pend_q) < PERIOD_NS));

  // R3: a pending offset moves to active on the boundary and is consumed
  p_pend_commit_r3: assert property (@(posedge clk) disable iff (rst)
    (commit_i && pend_vld && !load_i) |=> (act_q == $past(pend_q)) && !pend_vld);

endmodule

// File: rtl/ident_trig_sched.sv
module ident_trig_sched #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fire_i,
  output logic             trig_o
);

  logic [CNT_W-1:0] rem_q;
  logic             armed_q;
  logic             trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      if (arm_i) begin
        rem_q   <= cnt_i;
        armed_q <= (cnt_i != '0);
      end else if (armed_q && fire_i) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) begin
          armed_q <= 1'b0;
          trig_q  <= 1'b1;
        end
      end
    end
  end

  assign trig_o = trig_q;

  // R6: an idle scheduler never raises a trigger on the next cycle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !arm_i) |=> !trig_q);

endmodule

// File: rtl/ident_resynth.sv
module ident_resynth #(
  parameter int TIME_W    = 64,
  parameter int PERIOD_NS = 10000,
  parameter int STEP_NS   = 8,
  parameter int CNT_W     = 16,
  localparam int PH_W     = $clog2(PERIOD_NS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] net_time_i,
  input  logic              ofs_load_i,
  input  logic [PH_W-1:0]   ofs_val_i,
  input  logic              arm_i,
  input  logic [CNT_W-1:0]  arm_cnt_i,
  output logic              ident_o,
  output logic              trig_o,
  output logic              resync_o
);

  logic [PH_W-1:0] ofs_act;
  logic            fire;
  logic            jump;
  logic            ident_q;
  logic            resync_q;

  ident_offset_reg #(
    .PERIOD_NS(PERIOD_NS),
    .PH_W     (PH_W)
  ) u_ofs (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ofs_load_i),
    .val_i   (ofs_val_i),
    .commit_i(fire),
    .ofs_o   (ofs_act)
  );

  ident_phase_track #(
    .TIME_W   (TIME_W),
    .PERIOD_NS(PERIOD_NS),
    .STEP_NS  (STEP_NS),
    .PH_W     (PH_W)
  ) u_track (
    .clk   (clk),
    .rst   (rst),
    .time_i(net_time_i),
    .ofs_i (ofs_act),
    .fire_o(fire),
    .jump_o(jump)
  );

  ident_trig_sched #(
    .CNT_W(CNT_W)
  ) u_sched (
    .clk   (clk),
    .rst   (rst),
    .arm_i (arm_i),
    .cnt_i (arm_cnt_i),
    .fire_i(fire),
    .trig_o(trig_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ident_q  <= 1'b0;
      resync_q <= 1'b0;
    end else begin
      ident_q  <= fire;
      resync_q <= jump;
    end
  end

  assign ident_o  = ident_q;
  assign resync_o = resync_q;

  // R2: without a discontinuity an ident pulse lasts one cycle
  p_single_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    ident_o |=> (resync_o || !ident_o));

  // R5: a trigger only ever coincides with an ident pulse
  p_trig_on_ident_r5: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> ident_o);

endmodule

// File: tb/ident_resynth_bench.sv
module ident_resynth_bench;

  localparam int P = 10000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tm = '0;
  logic        ld = 1'b0;
  logic [13:0] lv = '0;
  logic        arm = 1'b0;
  logic [15:0] acnt = '0;
  logic        ident, trig, resync;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // bench model state
  int unsigned m_act = 0, m_pend = 0;
  bit          m_pv = 0, m_first = 1, m_armed = 0;
  int unsigned m_rem = 0;
  logic [63:0] m_prev = '0, tnext;
  int          npulse = 0, ntrig = 0, nresync = 0;

  always #5 clk = ~clk;

  ident_resynth u_ident_resynth (
    .clk(clk), .rst(rst), .net_time_i(tm), .ofs_load_i(ld), .ofs_val_i(lv),
    .arm_i(arm), .arm_cnt_i(acnt), .ident_o(ident), .trig_o(trig),
    .resync_o(resync)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0b expected=%0b at t=%0d", req, act, exp, tm);
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare after it
  task automatic tick(input bit do_ld, input int unsigned ldv,
                      input bit do_arm, input int unsigned n);
    bit e_fire, e_res, e_trig;
    @(negedge clk);
    ld = do_ld; lv = 14'(ldv); arm = do_arm; acnt = 16'(n);
    tm = tnext;
    e_fire = (((64'(tnext % P) + P - m_act) % P) < 8);
    e_res  = m_first || (tnext != m_prev + 8);
    e_trig = !do_arm && m_armed && e_fire && (m_rem == 1);
    if (e_fire && m_pv) begin m_act = m_pend; m_pv = 0; end
    if (do_ld) begin m_pend = (ldv >= P) ? ldv - P : ldv; m_pv = 1; end
    if (do_arm) begin m_armed = (n != 0); m_rem = n; end
    else if (m_armed && e_fire) begin
      if (m_rem == 1) m_armed = 0;
      m_rem--;
    end
    m_first = 0; m_prev = tnext; tnext = tnext + 8;
    @(posedge clk); #1;
    chk("R2/R3/R4 ident", ident, e_fire);   // placement with active offset
    chk("R7/R8 resync", resync, e_res);
    chk("R5/R6 trig", trig, e_trig);
    npulse += int'(e_fire); ntrig += int'(e_trig); nresync += int'(e_res);
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) tick(0, 0, 0, 0);
  endtask

  initial begin
    tnext = 64'd1_700_000_000_000_000_123;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tm = 64'd12345 + 64'(i * 100);
      @(posedge clk); #1;
      chk("R1 ident", ident, 1'b0);
      chk("R1 trig", trig, 1'b0);
      chk("R1 resync", resync, 1'b0);
    end
    @(negedge clk); rst = 0;
    // R8: first sample is a resync; R2 sweep with zero offset
    npulse = 0;
    run(3750);
    compared++;
    if (npulse != 3) begin mismatched++;
      $display("FAIL R2 pulse count: actual=%0d expected=3", npulse); end
    // R3: load mid-period, applies after next boundary
    run(400);
    tick(1, 2500, 0, 0);
    run(2600);
    // R4: over-range value 12345 becomes 2345
    tick(1, 12345, 0, 0);
    run(2600);
    // R3: second load replaces pending, top value 9999
    tick(1, 100, 0, 0);
    run(10);
    tick(1, 9999, 0, 0);
    run(2600);
    // R7: forward and backward jumps
    nresync = 0;
    tnext = tnext + 64'd777_777;
    run(1300);
    tnext = tnext - 64'd5_003;
    run(1300);
    compared++;
    if (nresync != 2) begin mismatched++;
      $display("FAIL R7 resync count: actual=%0d expected=2", nresync); end
    // R5: trigger on the third ident pulse
    ntrig = 0;
    tick(0, 0, 1, 3);
    run(4000);
    tick(0, 0, 1, 1);
    run(1300);
    compared++;
    if (ntrig != 2) begin mismatched++;
      $display("FAIL R5 trigger count: actual=%0d expected=2", ntrig); end
    // R6: arm then cancel with zero, then re-arm replaces
    ntrig = 0;
    tick(0, 0, 1, 2);
    run(100);
    tick(0, 0, 1, 0);
    run(3000);
    tick(0, 0, 1, 5);
    run(200);
    tick(0, 0, 1, 1);
    run(1300);
    compared++;
    if (ntrig != 1) begin mismatched++;
      $display("FAIL R6 trigger count: actual=%0d expected=1", ntrig); end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule